// File: doc/BRIEF.md
# Row-Parallel Bit-Serial Gray-Scale ALU

This block sits at the end of one sensor row of a vision chip. The row converter sends each 6-bit gray level one bit at a time. A small deserializer turns each conversion frame back into a parallel word. A frame is one idle sampling clock followed by six data clocks. Finished words can be pushed into a short column pipeline. The pipeline moves every stored word one column further on each enabled cycle.

An 11-bit accumulator datapath works on these words. It is built from eleven identical one-bit adder slices with ripple carry. An external controller sends a 2-bit operation code with a go strobe. The operations are clear, accumulate by adding, accumulate by subtracting, and signed magnitude compare. The controller also chooses the second operand: the word at the tail of the column pipeline, or the word most recently assembled. Eleven bits are enough to add nine full-scale samples, which covers a 3x3 neighbourhood sum. The result and the compare flags are held in output registers.

Top module: `row_gray_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the assembled word, the bit counter, the column pipeline, the accumulator, `res_valid`, `word_ready`, `flag_gt` and `flag_eq` are all cleared to zero.
- R2: A frame starts with a clock where `ser_start` is high. That clock carries no data. On the next six clocks `ser_bit` carries the value, most significant bit first. `word_ready` is high for exactly the one cycle after the sixth data clock, and `word_out` then holds the value until the next frame completes.
- R3: If `ser_start` rises again before six data bits have arrived, the partial value is dropped. No `word_ready` pulse is produced for it, and the new frame is assembled from its own six bits.
- R4: On a cycle with `shift_en` high, column 0 loads `word_out` and each column i loads column i-1. `tail_word` shows the last column (index 3 with default parameters). Without `shift_en` the columns hold their values.
- R5: The second ALU operand is `tail_word` when `b_sel` is 0 and `word_out` when `b_sel` is 1. It is zero-extended from 6 to 11 bits.
- R6: `op_go` with `op_code` 2'b00 sets the accumulator to zero.
- R7: `op_go` with `op_code` 2'b01 sets the accumulator to accumulator plus operand, modulo 2^11. Nine additions of 63 starting from zero give 567.
- R8: `op_go` with `op_code` 2'b10 sets the accumulator to accumulator minus operand, as an 11-bit two's complement value. For example, 0 minus 5 gives 11'h7FB.
- R9: `op_go` with `op_code` 2'b11 sets `flag_gt` when the accumulator, read as signed, is greater than the operand. It sets `flag_eq` when they are equal. The accumulator is left unchanged. The flags change only on a compare and are never both high.
- R10: `res_valid` is high for exactly the cycle after each `op_go`. Without `op_go` the accumulator holds its value.
- R11: When `op_go` and `shift_en` are high in the same cycle, the ALU uses the column values from before the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_start | input | 1 | Marks the sampling clock that opens a frame |
| ser_bit | input | 1 | Serial data bit, MSB first |
| shift_en | input | 1 | Advance the column pipeline by one column |
| b_sel | input | 1 | Second operand select: 0 = tail column, 1 = newest word |
| op_go | input | 1 | Execute `op_code` this cycle |
| op_code | input | 2 | 00 clear, 01 add, 10 subtract, 11 compare |
| word_out | output | 6 | Most recently assembled word |
| word_ready | output | 1 | One-cycle pulse when a word completes |
| tail_word | output | 6 | Word in the last column |
| acc_out | output | 11 | Accumulator, signed two's complement |
| res_valid | output | 1 | Pulse one cycle after `op_go` |
| flag_gt | output | 1 | Last compare: accumulator greater than operand |
| flag_eq | output | 1 | Last compare: accumulator equal to operand |

## Verification
Several properties are checked on every cycle:
- `word_ready` and `res_valid` are single-cycle pulses, and `res_valid` appears only after `op_go`.
- The accumulator holds without `op_go` and is left unchanged by a compare.
- A clear gives zero, and the two compare flags are never both set.

Other behaviours need complete value sequences, so only the bench scenarios can show them:
- Correct MSB-first assembly, and the abort on a restarted frame.
- Column ordering, the operand choice, and the use of pre-shift values when shift and op coincide.
- The signed arithmetic: the nine-sample sum, negative differences, and compares near zero.

// File: rtl/row_gray_alu_pkg.sv
package row_gray_alu_pkg;
  localparam int unsigned PIX_W_DEF  = 6;
  localparam int unsigned ACC_W_DEF  = 11;
  localparam int unsigned N_COLS_DEF = 4;

  typedef enum logic [1:0] {
    OP_CLR = 2'b00,
    OP_ADD = 2'b01,
    OP_SUB = 2'b10,
    OP_CMP = 2'b11
  } alu_op_e;
endpackage

// File: rtl/row_deser.sv
module row_deser #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         bit_in,
  output logic [W-1:0] word_q,
  output logic         ready_q
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] left_q;
  logic [W-1:0]  sh_q;
  logic [W-1:0]  sh_nxt;

  assign sh_nxt = {sh_q[W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      if (start) begin
        // sampling clock: no data bit, arm the counter
        left_q <= CW'(W);
        sh_q   <= '0;
      end else if (left_q != '0) begin
        sh_q   <= sh_nxt;
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) begin
          word_q  <= sh_nxt;
          ready_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/col_shift.sv
module col_shift #(
  parameter int unsigned W = 6,
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] tail
);
  logic [W-1:0] cols_q [N];

  for (genvar i = 0; i < N; i++) begin : g_col
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)     cols_q[i] <= '0;
        else if (en) cols_q[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)     cols_q[i] <= '0;
        else if (en) cols_q[i] <= cols_q[i-1];
      end
    end
  end

  assign tail = cols_q[N-1];
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic y,
  output logic cout
);
  logic p;
  assign p    = a ^ b;
  assign y    = p ^ cin;
  assign cout = (a & b) | (cin & p);
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu #(
  parameter int unsigned W = 11
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W:0]   c;
  logic [W-1:0] bx;

  assign bx   = b ^ {W{sub}};
  assign c[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_slice
    alu_bit_slice u_slice (
      .a   (a[i]),
      .b   (bx[i]),
      .cin (c[i]),
      .y   (sum[i]),
      .cout(c[i+1])
    );
  end

  assign ovf = c[W] ^ c[W-1];
endmodule

// File: rtl/row_gray_alu.sv
module row_gray_alu
  import row_gray_alu_pkg::*;
#(
  parameter int unsigned PIX_W  = PIX_W_DEF,
  parameter int unsigned ACC_W  = ACC_W_DEF,
  parameter int unsigned N_COLS = N_COLS_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_start,
  input  logic             ser_bit,
  input  logic             shift_en,
  input  logic             b_sel,
  input  logic             op_go,
  input  logic [1:0]       op_code,
  output logic [PIX_W-1:0] word_out,
  output logic             word_ready,
  output logic [PIX_W-1:0] tail_word,
  output logic [ACC_W-1:0] acc_out,
  output logic             res_valid,
  output logic             flag_gt,
  output logic             flag_eq
);
  localparam int unsigned EXT_W = ACC_W - PIX_W;

  alu_op_e          op;
  logic [PIX_W-1:0] b_pix;
  logic [ACC_W-1:0] b_ext;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] alu_sum;
  logic             alu_ovf;
  logic             do_sub;
  logic             lt_w;
  logic             eq_w;

  assign op = alu_op_e'(op_code);

  row_deser #(.W(PIX_W)) u_deser (
    .clk    (clk),
    .rst    (rst),
    .start  (ser_start),
    .bit_in (ser_bit),
    .word_q (word_out),
    .ready_q(word_ready)
  );

  col_shift #(.W(PIX_W), .N(N_COLS)) u_cols (
    .clk (clk),
    .rst (rst),
    .en  (shift_en),
    .din (word_out),
    .tail(tail_word)
  );

  assign b_pix  = b_sel ? word_out : tail_word;
  assign b_ext  = {{EXT_W{1'b0}}, b_pix};
  assign do_sub = (op == OP_SUB) || (op == OP_CMP);

  ripple_alu #(.W(ACC_W)) u_alu (
    .a  (acc_q),
    .b  (b_ext),
    .sub(do_sub),
    .sum(alu_sum),
    .ovf(alu_ovf)
  );

  // signed less-than from the difference sign corrected by overflow
  assign lt_w = alu_sum[ACC_W-1] ^ alu_ovf;
  assign eq_w = (alu_sum == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      res_valid <= 1'b0;
      flag_gt   <= 1'b0;
      flag_eq   <= 1'b0;
    end else begin
      res_valid <= op_go;
      if (op_go) begin
        unique case (op)
          OP_CLR: acc_q <= '0;
          OP_ADD: acc_q <= alu_sum;
          OP_SUB: acc_q <= alu_sum;
          OP_CMP: begin
            flag_gt <= !lt_w && !eq_w;
            flag_eq <= eq_w;
          end
          default: acc_q <= acc_q;
        endcase
      end
    end
  end

  assign acc_out = acc_q;
endmodule

// File: rtl/row_gray_alu_chk.sv
module row_gray_alu_chk #(
  parameter int unsigned PIX_W = 6,
  parameter int unsigned ACC_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             op_go,
  input logic [1:0]       op_code,
  input logic             word_ready,
  input logic [ACC_W-1:0] acc_out,
  input logic             res_valid,
  input logic             flag_gt,
  input logic             flag_eq
);
  // R2: completion strobe lasts one cycle
  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    word_ready |=> !word_ready);

  // R6: clear yields zero
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (op_go && op_code == 2'b00) |=> (acc_out == '0));

  // R9: compare leaves accumulator alone
  assert_cmp_keeps_acc_R9: assert property (@(posedge clk) disable iff (rst)
    (op_go && op_code == 2'b11) |=> $stable(acc_out));

  // R9: flags exclusive
  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(flag_gt && flag_eq));

  // R10: result valid follows a go strobe
  assert_valid_after_go_R10: assert property (@(posedge clk) disable iff (rst)
    op_go |=> res_valid);

  // R10: no go, no valid and no accumulator change
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !op_go |=> (!res_valid && $stable(acc_out)));
endmodule

bind row_gray_alu row_gray_alu_chk #(.PIX_W(PIX_W), .ACC_W(ACC_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .op_go     (op_go),
  .op_code   (op_code),
  .word_ready(word_ready),
  .acc_out   (acc_out),
  .res_valid (res_valid),
  .flag_gt   (flag_gt),
  .flag_eq   (flag_eq)
);

// File: tb/row_gray_alu_tb_top.sv
`timescale 1ns/1ps
module row_gray_alu_tb_top;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_start = 1'b0;
  logic        ser_bit = 1'b0;
  logic        shift_en = 1'b0;
  logic        b_sel = 1'b0;
  logic        op_go = 1'b0;
  logic [1:0]  op_code = 2'b00;
  logic [5:0]  word_out;
  logic        word_ready;
  logic [5:0]  tail_word;
  logic [10:0] acc_out;
  logic        res_valid;
  logic        flag_gt;
  logic        flag_eq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [5:0]  m_word;
  logic [5:0]  m_cols [NC];
  logic [10:0] m_acc;
  logic        m_gt, m_eq;

  always #5 clk = ~clk;

  row_gray_alu dut_i (
    .clk(clk), .rst(rst), .ser_start(ser_start), .ser_bit(ser_bit),
    .shift_en(shift_en), .b_sel(b_sel), .op_go(op_go), .op_code(op_code),
    .word_out(word_out), .word_ready(word_ready), .tail_word(tail_word),
    .acc_out(acc_out), .res_valid(res_valid), .flag_gt(flag_gt),
    .flag_eq(flag_eq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic cmp_gt(input logic [10:0] a, input logic [5:0] b);
    logic signed [11:0] sa, sb;
    sa = {a[10], a};
    sb = {6'b0, b};
    return sa > sb;
  endfunction

  // R2: frame = start clock then six bits MSB first
  task automatic send_word(input logic [5:0] v);
    @(negedge clk);
    ser_start = 1'b1;
    for (int i = 5; i >= 0; i--) begin
      @(negedge clk);
      ser_start = 1'b0;
      ser_bit = v[i];
      chk("R2", "word_ready early", word_ready, 1'b0);
    end
    @(negedge clk);
    ser_bit = 1'b0;
    chk("R2", "word_ready", word_ready, 1'b1);
    chk("R2", "word_out", word_out, v);
    m_word = v;
    @(negedge clk);
    chk("R2", "word_ready drop", word_ready, 1'b0);
  endtask

  // one cycle of shift and/or op; model uses pre-shift state (R11)
  task automatic step(input bit sh, input bit go, input logic [1:0] op,
                      input bit sel);
    logic [5:0] b;
    @(negedge clk);
    shift_en = sh; op_go = go; op_code = op; b_sel = sel;
    b = sel ? m_word : m_cols[NC-1];
    if (go) begin
      case (op)
        2'b00: m_acc = '0;
        2'b01: m_acc = m_acc + {5'b0, b};
        2'b10: m_acc = m_acc - {5'b0, b};
        default: begin
          m_gt = cmp_gt(m_acc, b);
          m_eq = (m_acc == {5'b0, b});
        end
      endcase
    end
    if (sh) begin
      for (int i = NC-1; i > 0; i--) m_cols[i] = m_cols[i-1];
      m_cols[0] = m_word;
    end
    @(negedge clk);
    shift_en = 1'b0; op_go = 1'b0;
    chk("R10", "res_valid", res_valid, go);
    chk(op == 2'b10 ? "R8" : op == 2'b01 ? "R7" : op == 2'b00 ? "R6" : "R9",
        "acc_out", acc_out, m_acc);
    chk("R9", "flag_gt", flag_gt, m_gt);
    chk("R9", "flag_eq", flag_eq, m_eq);
    chk("R4", "tail_word", tail_word, m_cols[NC-1]);
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    m_word = '0; m_acc = '0; m_gt = 1'b0; m_eq = 1'b0;
    for (int i = 0; i < NC; i++) m_cols[i] = '0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "acc", acc_out, 11'd0);
    chk("R1", "word", word_out, 6'd0);
    chk("R1", "ready", word_ready, 1'b0);
    chk("R1", "valid", res_valid, 1'b0);
    chk("R1", "flags", {flag_gt, flag_eq}, 2'b00);
    chk("R1", "tail", tail_word, 6'd0);

    // R2: MSB first with asymmetric pattern
    send_word(6'b100110);
    send_word(6'b000001);

    // R3: abort after three bits, then a full frame
    @(negedge clk);
    ser_start = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      ser_start = 1'b0; ser_bit = 1'b1;
      chk("R3", "no ready", word_ready, 1'b0);
    end
    send_word(6'b010101);
    chk("R3", "restarted word", word_out, 6'b010101);

    // R7: nine full-scale adds give 567
    send_word(6'd63);
    step(1'b0, 1'b1, 2'b00, 1'b1);
    for (int i = 0; i < 9; i++) step(1'b0, 1'b1, 2'b01, 1'b1);
    chk("R7", "nine sum", acc_out, 11'd567);

    // R8: 0 - 5 = 11'h7FB, then compare -5 vs 5
    send_word(6'd5);
    step(1'b0, 1'b1, 2'b00, 1'b1);
    step(1'b0, 1'b1, 2'b10, 1'b1);
    chk("R8", "neg diff", acc_out, 11'h7FB);
    step(1'b0, 1'b1, 2'b11, 1'b1);
    chk("R9", "neg not gt", {flag_gt, flag_eq}, 2'b00);
    // R9: equal compare
    step(1'b0, 1'b1, 2'b00, 1'b1);
    step(1'b0, 1'b1, 2'b01, 1'b1);
    step(1'b0, 1'b1, 2'b11, 1'b1);
    chk("R9", "equal", {flag_gt, flag_eq}, 2'b01);

    // R4/R5: fill columns, op on tail column
    for (int i = 0; i < NC; i++) begin
      send_word(6'(10 + i));
      step(1'b1, 1'b0, 2'b00, 1'b0);
    end
    chk("R4", "tail first", tail_word, 6'd10);
    step(1'b0, 1'b1, 2'b01, 1'b0);
    // R11: op and shift together uses pre-shift tail
    step(1'b1, 1'b1, 2'b01, 1'b0);
    chk("R11", "pre-shift tail", acc_out, m_acc);

    // constrained random mix
    for (int it = 0; it < 300; it++) begin
      int unsigned k;
      k = $urandom % 5;
      case (k)
        0: send_word(6'($urandom));
        1: step(1'b1, 1'b0, 2'b00, 1'($urandom));
        2, 3: step(1'b0, 1'b1, 2'($urandom), 1'($urandom));
        default: step(1'b1, 1'b1, 2'($urandom), 1'($urandom));
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule